// File: doc/BRIEF.md
# Frame Mailbox Network Interface

This block is a minimal network interface that a host processor drives entirely through programmed I/O on a small register window. It keeps exactly one receive frame and one transmit frame, each in its own byte buffer. To transmit, the host sets a byte count and then pushes the frame one byte per write into a data port. When the number of bytes written reaches the count, the frame leaves on an outgoing byte stream. A received frame arrives on an incoming byte stream, and the host pulls it out one byte per read of a second data port while a count register tells it how many bytes remain.

A single interrupt control word holds a transmit-done flag, a receive-done flag and a self-test flag. The interrupt line is high while any of them is set. A busy flag is derived from that word. The block takes a new receive frame only while busy is clear, so the host must acknowledge each received frame before the next one can arrive. Writing the interrupt control word clears one flag at a time in priority order. A write that carries only the self-test bit soft-resets the block and raises the test flag.

Top module: `frame_mbox_nic`

## Requirements
- R1: The decoder uses a 6-bit byte offset. Offset 0x00 reads 0x464D4258 and offset 0x04 reads 0x4E494331. Offset 0x08 reads busy in bit 0, 0x0C reads the RX count, 0x10 reads the TX count and 0x14 reads the interrupt control word. Offset 0x18 (interrupt info), offset 0x20 (TX data port) and every undefined offset read as 0.
- R2: After reset, busy reads 1, both counts read 0, the interrupt control word reads 0 and irq is low.
- R3: A write to offset 0x10 stores the value if it is no larger than MAX_BYTES (1514 by default) and stores 0 otherwise. Every such write also returns the TX write pointer to 0.
- R4: Each write to offset 0x20 stores wdata[7:0] at the write pointer and advances the pointer. When the pointer reaches the TX count, the frame is sent on tx_data in write order, with tx_last on the final byte. At that point the TX count reads 0, interrupt control bit 0 (TX-done) is set and busy becomes 1.
- R5: While a frame is still being sent, a write to offset 0x20 is held with bus_stall high. It completes only after the last byte has been accepted on the stream.
- R6: rx_ready is low between frames unless busy is 0 and the RX count is below MAX_BYTES.
- R7: When a received frame ends (a beat with rx_last), the RX count becomes its length, the read pointer returns to the first byte, interrupt control bit 1 (RX-done) is set and busy becomes 1.
- R8: A read of offset 0x1C returns the next received byte in arrival order and decrements the RX count while the count is nonzero. Once the count is 0, the port reads 0 and the count stays 0.
- R9: A received frame longer than MAX_BYTES keeps its first MAX_BYTES bytes and discards the rest, and its RX count is MAX_BYTES.
- R10: irq is high exactly while the interrupt control word is nonzero. A read of offset 0x14 returns the current word and then clears bit 31 (test).
- R11: A write to offset 0x14 is decoded in priority order. If bit 0 is set, only TX-done is cleared. Otherwise, if bit 1 is set, only RX-done is cleared. Otherwise, if bit 31 is set, both counts, both pointers and all flags are cleared and the test flag is then set. A write of zero changes no flag. After any such write, busy equals (interrupt control word != 0).
- R12: Writes to offsets 0x00, 0x08, 0x0C, 0x18 and 0x1C have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Register access request, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_ofs | input | 6 | Byte offset into the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current request, valid in the same cycle |
| bus_stall | output | 1 | High while the current request is held |
| irq | output | 1 | Interrupt, high while any interrupt flag is set |
| rx_valid | input | 1 | Incoming frame byte valid |
| rx_data | input | 8 | Incoming frame byte |
| rx_last | input | 1 | Final byte of the incoming frame |
| rx_ready | output | 1 | Block can take an incoming byte |
| tx_valid | output | 1 | Outgoing frame byte valid |
| tx_data | output | 8 | Outgoing frame byte |
| tx_last | output | 1 | Final byte of the outgoing frame |
| tx_ready | input | 1 | Sink accepts the outgoing byte |

## Verification
On every cycle, the assertions check that both counts stay within MAX_BYTES and that a draining read lowers the RX count by exactly one. They also check that the outgoing stream holds its byte steady under backpressure and starts as soon as a transmit completes, that a finished receive frame closes rx_ready, and that flag clearing, the read-clear of the test bit and the soft reset act with the right priority. Only the bench's scenarios can show that byte order survives both buffers for every frame length, that truncation keeps the right bytes, that count clamping and write-pointer rewinds behave correctly, and that writes to read-only offsets and reads of the zero offsets leave everything as it was.

// File: rtl/nic_pkg.sv
package nic_pkg;
  // Register offsets inside the 6-bit window
  localparam logic [5:0] OFS_ID_LO  = 6'h00;
  localparam logic [5:0] OFS_ID_HI  = 6'h04;
  localparam logic [5:0] OFS_BUSY   = 6'h08;
  localparam logic [5:0] OFS_RXCNT  = 6'h0C;
  localparam logic [5:0] OFS_TXCNT  = 6'h10;
  localparam logic [5:0] OFS_ICTL   = 6'h14;
  localparam logic [5:0] OFS_INFO   = 6'h18;
  localparam logic [5:0] OFS_RXPORT = 6'h1C;
  localparam logic [5:0] OFS_TXPORT = 6'h20;

  localparam logic [31:0] ID_WORD_LO = 32'h464D_4258;
  localparam logic [31:0] ID_WORD_HI = 32'h4E49_4331;

  // Interrupt control flags, packed as {test, rx_done, tx_done}
  typedef struct packed {
    logic test;
    logic rx_done;
    logic tx_done;
  } ictl_flags_t;

  function automatic logic [31:0] ictl_word(input ictl_flags_t f);
    return {f.test, 29'd0, f.rx_done, f.tx_done};
  endfunction

  // Oversized transmit length requests collapse to zero
  function automatic logic [31:0] clamp_tx_len(input logic [31:0] v, input int unsigned lim);
    return (v > lim) ? 32'd0 : v;
  endfunction

  // Increment that stops at the buffer capacity
  function automatic logic [31:0] sat_inc(input logic [31:0] v, input int unsigned lim);
    return (v >= lim) ? lim : v + 32'd1;
  endfunction
endpackage

// File: rtl/nic_irq_ctl.sv
module nic_irq_ctl
  import nic_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ictl_wr,
  input  logic        ictl_rd,
  input  logic [2:0]  wr_bits,     // {bit31, bit1, bit0} of the write data
  input  logic        tx_done_evt,
  input  logic        rx_done_evt,
  output logic [31:0] ictl_value,
  output logic        busy,
  output logic        irq,
  output logic        soft_rst
);
  ictl_flags_t flags_q, flags_d;
  logic        busy_q, busy_d;

  always_comb begin
    flags_d  = flags_q;
    busy_d   = busy_q;
    soft_rst = 1'b0;
    if (ictl_wr) begin
      if (wr_bits[0]) begin
        flags_d.tx_done = 1'b0;
      end else if (wr_bits[1]) begin
        flags_d.rx_done = 1'b0;
      end else if (wr_bits[2]) begin
        flags_d      = '0;
        flags_d.test = 1'b1;
        soft_rst     = 1'b1;
      end
      busy_d = |flags_d;
    end else if (ictl_rd) begin
      flags_d.test = 1'b0;
    end
    if (tx_done_evt) begin
      flags_d.tx_done = 1'b1;
      busy_d          = 1'b1;
    end
    if (rx_done_evt) begin
      flags_d.rx_done = 1'b1;
      busy_d          = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      busy_q  <= 1'b1;
    end else begin
      flags_q <= flags_d;
      busy_q  <= busy_d;
    end
  end

  assign ictl_value = ictl_word(flags_q);
  assign busy       = busy_q;
  assign irq        = |flags_q;

  assert_rd_clears_test_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ictl_rd && !ictl_wr |=> !ictl_value[31]);
  assert_selftest_sets_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> ictl_value[31] && busy);
  assert_tx_clear_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ictl_wr && wr_bits[0] && !tx_done_evt && !rx_done_evt
      |=> !ictl_value[0] && (ictl_value[1] == $past(ictl_value[1])));
  assert_busy_after_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ictl_wr |=> busy == (ictl_value != 32'd0));
endmodule

// File: rtl/nic_tx_path.sv
module nic_tx_path
  import nic_pkg::*;
#(
  parameter int unsigned MAX_BYTES = 1514,
  parameter int unsigned CNT_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             cnt_wr,
  input  logic [31:0]      cnt_wdata,
  input  logic             data_wr,
  input  logic [7:0]       data_byte,
  input  logic             tx_ready,
  output logic [CNT_W-1:0] tx_count,
  output logic             send_busy,
  output logic             tx_done_evt,
  output logic             tx_valid,
  output logic [7:0]       tx_data,
  output logic             tx_last
);
  localparam int unsigned DEPTH = 1 << CNT_W;
  localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_BYTES);

  logic [7:0]       buf_q [DEPTH];
  logic [CNT_W-1:0] count_q, wptr_q, send_len_q, send_idx_q;
  logic             send_q;

  logic             data_take, ptr_room;
  logic [CNT_W-1:0] wptr_nxt;

  assign data_take   = data_wr && !send_q;
  assign ptr_room    = wptr_q < CAP;
  assign wptr_nxt    = wptr_q + 1'b1;
  assign tx_done_evt = data_take && ptr_room && (wptr_nxt == count_q);

  always_ff @(posedge clk) begin
    if (data_take && ptr_room) buf_q[wptr_q] <= data_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q    <= '0;
      wptr_q     <= '0;
      send_q     <= 1'b0;
      send_len_q <= '0;
      send_idx_q <= '0;
    end else begin
      if (soft_rst) begin
        count_q <= '0;
        wptr_q  <= '0;
      end else if (cnt_wr) begin
        count_q <= CNT_W'(clamp_tx_len(cnt_wdata, MAX_BYTES));
        wptr_q  <= '0;
      end else if (tx_done_evt) begin
        count_q    <= '0;
        wptr_q     <= '0;
        send_q     <= 1'b1;
        send_len_q <= count_q;
        send_idx_q <= '0;
      end else if (data_take && ptr_room) begin
        wptr_q <= wptr_nxt;
      end
      if (send_q && tx_ready) begin
        if (tx_last) send_q <= 1'b0;
        else         send_idx_q <= send_idx_q + 1'b1;
      end
    end
  end

  assign tx_count  = count_q;
  assign send_busy = send_q;
  assign tx_valid  = send_q;
  assign tx_data   = buf_q[send_idx_q];
  assign tx_last   = send_q && (send_idx_q == send_len_q - 1'b1);

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CAP);
  assert_done_starts_stream_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done_evt |=> tx_valid && (tx_count == '0));
  assert_hold_under_backpressure_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));
endmodule

// File: rtl/nic_rx_path.sv
module nic_rx_path
  import nic_pkg::*;
#(
  parameter int unsigned MAX_BYTES = 1514,
  parameter int unsigned CNT_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             busy,
  input  logic             port_rd,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  input  logic             rx_last,
  output logic             rx_ready,
  output logic [CNT_W-1:0] rx_count,
  output logic [7:0]       port_byte,
  output logic             rx_done_evt
);
  localparam int unsigned DEPTH = 1 << CNT_W;
  localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_BYTES);

  logic [7:0]       buf_q [DEPTH];
  logic [CNT_W-1:0] count_q, rptr_q, wptr_q;
  logic             active_q;

  logic             can_start, beat;
  logic [CNT_W-1:0] idx, len_after;

  assign can_start   = !busy && (count_q < CAP);
  assign rx_ready    = active_q || can_start;
  assign beat        = rx_valid && rx_ready;
  assign idx         = active_q ? wptr_q : '0;
  assign len_after   = CNT_W'(sat_inc(32'(idx), MAX_BYTES));
  assign rx_done_evt = beat && rx_last;

  always_ff @(posedge clk) begin
    if (beat && (idx < CAP)) buf_q[idx] <= rx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q  <= '0;
      rptr_q   <= '0;
      wptr_q   <= '0;
      active_q <= 1'b0;
    end else begin
      if (soft_rst) begin
        count_q <= '0;
        rptr_q  <= '0;
      end else if (port_rd && (count_q != '0)) begin
        count_q <= count_q - 1'b1;
        rptr_q  <= rptr_q + 1'b1;
      end
      if (rx_done_evt) begin
        count_q  <= len_after;
        rptr_q   <= '0;
        active_q <= 1'b0;
      end else if (beat) begin
        active_q <= 1'b1;
        wptr_q   <= len_after;
      end
    end
  end

  assign rx_count  = count_q;
  assign port_byte = (count_q != '0) ? buf_q[rptr_q] : 8'd0;

  assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CAP);
  assert_done_closes_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done_evt |=> !rx_ready);
  assert_drain_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    port_rd && (count_q != '0) && !soft_rst && !rx_done_evt
      |=> count_q == $past(count_q) - 1'b1);
endmodule

// File: rtl/frame_mbox_nic.sv
module frame_mbox_nic
  import nic_pkg::*;
#(
  parameter int unsigned MAX_BYTES = 1514
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_req,
  input  logic        bus_we,
  input  logic [5:0]  bus_ofs,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        bus_stall,
  output logic        irq,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_last,
  output logic        rx_ready,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  input  logic        tx_ready
);
  localparam int unsigned CNT_W = $clog2(MAX_BYTES + 1);

  logic             acc, wr, rd;
  logic             send_busy, tx_done_evt, rx_done_evt, soft_rst, busy;
  logic [CNT_W-1:0] tx_count, rx_count;
  logic [7:0]       port_byte;
  logic [31:0]      ictl_value;

  assign bus_stall = bus_req && bus_we && (bus_ofs == OFS_TXPORT) && send_busy;
  assign acc       = bus_req && !bus_stall;
  assign wr        = acc && bus_we;
  assign rd        = acc && !bus_we;

  nic_irq_ctl u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .ictl_wr     (wr && (bus_ofs == OFS_ICTL)),
    .ictl_rd     (rd && (bus_ofs == OFS_ICTL)),
    .wr_bits     ({bus_wdata[31], bus_wdata[1], bus_wdata[0]}),
    .tx_done_evt (tx_done_evt),
    .rx_done_evt (rx_done_evt),
    .ictl_value  (ictl_value),
    .busy        (busy),
    .irq         (irq),
    .soft_rst    (soft_rst)
  );

  nic_tx_path #(.MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W)) u_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst    (soft_rst),
    .cnt_wr      (wr && (bus_ofs == OFS_TXCNT)),
    .cnt_wdata   (bus_wdata),
    .data_wr     (wr && (bus_ofs == OFS_TXPORT)),
    .data_byte   (bus_wdata[7:0]),
    .tx_ready    (tx_ready),
    .tx_count    (tx_count),
    .send_busy   (send_busy),
    .tx_done_evt (tx_done_evt),
    .tx_valid    (tx_valid),
    .tx_data     (tx_data),
    .tx_last     (tx_last)
  );

  nic_rx_path #(.MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W)) u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst    (soft_rst),
    .busy        (busy),
    .port_rd     (rd && (bus_ofs == OFS_RXPORT)),
    .rx_valid    (rx_valid),
    .rx_data     (rx_data),
    .rx_last     (rx_last),
    .rx_ready    (rx_ready),
    .rx_count    (rx_count),
    .port_byte   (port_byte),
    .rx_done_evt (rx_done_evt)
  );

  always_comb begin
    case (bus_ofs)
      OFS_ID_LO:  bus_rdata = ID_WORD_LO;
      OFS_ID_HI:  bus_rdata = ID_WORD_HI;
      OFS_BUSY:   bus_rdata = {31'd0, busy};
      OFS_RXCNT:  bus_rdata = 32'(rx_count);
      OFS_TXCNT:  bus_rdata = 32'(tx_count);
      OFS_ICTL:   bus_rdata = ictl_value;
      OFS_RXPORT: bus_rdata = {24'd0, port_byte};
      default:    bus_rdata = 32'd0;
    endcase
  end

  assert_stall_only_while_sending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stall |-> tx_valid);
  assert_irq_tracks_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(tx_done_evt || rx_done_evt || soft_rst));
endmodule

// File: tb/frame_mbox_nic_tb_top.sv
`timescale 1ns/1ps
module frame_mbox_nic_tb_top;
  localparam int MAXB = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [5:0]  bus_ofs = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_stall, irq;
  logic        rx_valid = 1'b0, rx_last = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready;
  logic        tx_valid, tx_last;
  logic [7:0]  tx_data;
  logic        tx_ready = 1'b0;

  int checks = 0, fails = 0;
  logic [7:0] cap [64];
  int cap_n = 0, frames = 0, rdy_tick = 0;

  frame_mbox_nic #(.MAX_BYTES(MAXB)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_ofs(bus_ofs),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_stall(bus_stall), .irq(irq),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [5:0] ofs, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_ofs = ofs;
    #1 d = bus_rdata;
    @(posedge clk);
    #1 bus_req = 1'b0;
  endtask

  task automatic wr(input logic [5:0] ofs, input logic [31:0] v);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_ofs = ofs; bus_wdata = v;
    #1;
    while (bus_stall) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1 bus_req = 1'b0; bus_we = 1'b0;
  endtask

  function automatic logic [7:0] rx_pat(input int len, input int i);
    return 8'((len * 7 + i * 13 + 1) & 255);
  endfunction

  function automatic logic [7:0] tx_pat(input int len, input int i);
    return 8'((len * 29 + i * 5 + 3) & 255);
  endfunction

  task automatic send_rx(input int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = rx_pat(len, i); rx_last = (i == len - 1);
      #1;
      while (!rx_ready) begin
        @(negedge clk);
        #1;
      end
      @(posedge clk);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0;
  endtask

  // Outgoing stream sink with a stalling ready pattern
  initial begin
    forever begin
      @(negedge clk);
      if (tx_valid && tx_ready) begin
        if (cap_n < 64) cap[cap_n] = tx_data;
        cap_n++;
        if (tx_last) frames++;
      end
      @(posedge clk);
      #1 rdy_tick++;
      tx_ready = (rdy_tick % 3) != 0;
    end
  end

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int f0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2 reset state
    rd(6'h08, d); check("R2 busy", d, 32'd1);
    rd(6'h0C, d); check("R2 rx count", d, 32'd0);
    rd(6'h10, d); check("R2 tx count", d, 32'd0);
    rd(6'h14, d); check("R2 ictl", d, 32'd0);
    check("R2 irq", {31'd0, irq}, 32'd0);

    // R1 identification and zero offsets, full sweep of the window
    for (int o = 0; o < 64; o += 4) begin
      rd(6'(o), d);
      if (o == 0)                              check("R1 id lo", d, 32'h464D_4258);
      else if (o == 4)                         check("R1 id hi", d, 32'h4E49_4331);
      else if (o == 'h18 || o == 'h20 || o > 'h20) check("R1 zero offset", d, 32'd0);
    end

    // R12 writes to read-only offsets
    wr(6'h08, 32'd0);  rd(6'h08, d); check("R12 busy write", d, 32'd1);
    wr(6'h0C, 32'd5);  rd(6'h0C, d); check("R12 rx count write", d, 32'd0);
    wr(6'h00, 32'd7);  rd(6'h00, d); check("R12 id write", d, 32'h464D_4258);
    wr(6'h18, 32'd9);  rd(6'h18, d); check("R12 info write", d, 32'd0);
    wr(6'h1C, 32'd3);  rd(6'h0C, d); check("R12 rx port write", d, 32'd0);

    // R6 no reception while busy; zero ictl write recomputes busy (R11)
    #1 check("R6 ready while busy", {31'd0, rx_ready}, 32'd0);
    wr(6'h14, 32'd0);
    rd(6'h08, d); check("R11 zero write busy", d, 32'd0);
    #1 check("R6 ready when idle", {31'd0, rx_ready}, 32'd1);

    // R7 R8 R9 receive sweep over lengths around the capacity
    for (int len = 1; len <= MAXB + 3; len++) begin
      int keep;
      keep = (len > MAXB) ? MAXB : len;
      send_rx(len);
      #1 check("R6 ready after frame", {31'd0, rx_ready}, 32'd0);
      check("R10 irq on rx", {31'd0, irq}, 32'd1);
      rd(6'h0C, d); check("R7 R9 rx count", d, 32'(keep));
      rd(6'h14, d); check("R7 rx done flag", d, 32'd2);
      rd(6'h08, d); check("R7 busy", d, 32'd1);
      if (len == MAXB) begin
        wr(6'h14, 32'd2);
        #1 check("R6 full buffer blocks", {31'd0, rx_ready}, 32'd0);
      end
      for (int i = 0; i < keep; i++) begin
        rd(6'h1C, d); check("R8 R9 rx byte", d, {24'd0, rx_pat(len, i)});
      end
      rd(6'h1C, d); check("R8 empty port", d, 32'd0);
      rd(6'h0C, d); check("R8 count stays 0", d, 32'd0);
      wr(6'h14, 32'd2);
      rd(6'h14, d); check("R11 rx clear", d, 32'd0);
      rd(6'h08, d); check("R11 busy clear", d, 32'd0);
      check("R10 irq low", {31'd0, irq}, 32'd0);
    end

    // R3 clamp and pointer rewind
    wr(6'h10, 32'(MAXB + 1)); rd(6'h10, d); check("R3 over clamp", d, 32'd0);
    wr(6'h10, 32'hFFFF_FFFF); rd(6'h10, d); check("R3 huge clamp", d, 32'd0);
    wr(6'h10, 32'(MAXB));     rd(6'h10, d); check("R3 at cap", d, 32'(MAXB));
    wr(6'h10, 32'd3);
    wr(6'h20, 32'hA1); wr(6'h20, 32'hB2);
    f0 = frames; cap_n = 0;
    wr(6'h10, 32'd2);
    wr(6'h20, 32'h1C3); wr(6'h20, 32'hD4);
    wait (frames == f0 + 1);
    check("R3 rewind len", 32'(cap_n), 32'd2);
    check("R3 rewind byte0", {24'd0, cap[0]}, 32'hC3);
    check("R3 rewind byte1", {24'd0, cap[1]}, 32'hD4);
    wr(6'h14, 32'd1);

    // R4 R5 transmit sweep
    for (int len = 1; len <= MAXB; len++) begin
      f0 = frames; cap_n = 0;
      wr(6'h10, 32'(len));
      rd(6'h10, d); check("R3 count readback", d, 32'(len));
      for (int i = 0; i < len; i++) wr(6'h20, {24'd0, tx_pat(len, i)});
      rd(6'h10, d); check("R4 count cleared", d, 32'd0);
      @(negedge clk);
      bus_req = 1'b1; bus_we = 1'b1; bus_ofs = 6'h20; bus_wdata = 32'hEE;
      #1;
      if (frames == f0) check("R5 stall during send", {31'd0, bus_stall}, 32'd1);
      while (bus_stall) begin
        @(negedge clk);
        #1;
      end
      @(posedge clk);
      #1 bus_req = 1'b0; bus_we = 1'b0;
      check("R5 frame done before write", 32'(frames), 32'(f0 + 1));
      check("R4 length", 32'(cap_n), 32'(len));
      for (int i = 0; i < len; i++) check("R4 tx byte", {24'd0, cap[i]}, {24'd0, tx_pat(len, i)});
      rd(6'h14, d); check("R4 tx done flag", d, 32'd1);
      rd(6'h08, d); check("R4 busy", d, 32'd1);
      wr(6'h14, 32'd1);
      rd(6'h08, d); check("R11 tx clear busy", d, 32'd0);
    end

    // R11 priority and self-test
    send_rx(5);
    f0 = frames;
    wr(6'h10, 32'd2); wr(6'h20, 32'h11); wr(6'h20, 32'h22);
    wait (frames == f0 + 1);
    rd(6'h14, d); check("R11 both flags", d, 32'd3);
    wr(6'h14, 32'd3);
    rd(6'h14, d); check("R11 bit0 first", d, 32'd2);
    rd(6'h08, d); check("R11 busy kept", d, 32'd1);
    wr(6'h14, 32'h8000_0002);
    rd(6'h14, d); check("R11 bit1 before test", d, 32'd0);
    rd(6'h0C, d); check("R11 no reset on bit1", d, 32'd5);
    wr(6'h14, 32'h8000_0000);
    check("R10 irq on test", {31'd0, irq}, 32'd1);
    rd(6'h14, d); check("R11 test flag", d, 32'h8000_0000);
    rd(6'h14, d); check("R10 test cleared on read", d, 32'd0);
    check("R10 irq after read", {31'd0, irq}, 32'd0);
    rd(6'h0C, d); check("R11 reset rx count", d, 32'd0);
    rd(6'h08, d); check("R11 busy after test", d, 32'd1);
    wr(6'h14, 32'd0);
    rd(6'h08, d); check("R11 zero write", d, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule